// File: doc/BRIEF.md
# PCI Burst Target Data-Phase Controller

This block is the target side of a 32-bit PCI bus. It watches for the start of a bus transaction and decodes the address and command presented in that first cycle. When the address falls inside its window and the command is a supported memory read or write, it claims the transaction by asserting DEVSEL# in the very next cycle. It then runs the data phases of a single-word or burst transfer using the IRDY#/TRDY# handshake. All bus control lines are active low, and every decision is taken on the rising clock edge.

On reads, the controller leaves one turnaround cycle after the address phase. During that cycle it holds TRDY# high and keeps its AD drivers off. It fetches words from the local side through a request/ready pair and presents each one on AD with TRDY# low. On writes, it is ready from the first data phase. Each word that moves across the bus is handed to the local side with active-high byte enables and a one-cycle valid strobe. The local side can hold the bus in wait states by withholding read-ready or write-accept. After the last data phase, the controller spends one cycle with all its outputs released and then goes back to idle.

Top module: `pcit_burst_target`

## Requirements
- R1: The controller claims a transaction only when all of these hold: FRAME# is low at an edge where it was high at the previous edge, (AD & BAR_MASK) == BAR_BASE, and C/BE# carries one of the read commands 4'b0110, 4'b1100, 4'b1110 or one of the write commands 4'b0111, 4'b1111. DEVSEL# is then low in the next cycle, and lcl_addr_o and lcl_cmd_o hold the sampled address and command. Any other address phase leaves DEVSEL# high.
- R2: On a read, in the first cycle with DEVSEL# low, TRDY# is high and ad_oe_o is low (turnaround).
- R3: ad_oe_o is high only while DEVSEL# is low. It is high for every read data-phase cycle after the turnaround and is never high during a write.
- R4: A read word is taken from lcl_rd_data_i on an edge where both lcl_rd_req_o and lcl_rd_rdy_i are high. If ready is high during the turnaround, TRDY# is low with the first word on AD in the cycle right after the turnaround. Words appear on AD in fetch order.
- R5: A word transfers only on an edge where IRDY# and TRDY# are both low. If IRDY# is high while TRDY# is low, AD and TRDY# hold for the next cycle, and no extra read word is fetched. A read burst of N beats fetches exactly N words.
- R6: After a transfer edge with FRAME# high (the last phase), the next cycle has DEVSEL# high, TRDY# high and ad_oe_o low. DEVSEL# stays high for the cycle after that.
- R7: Each write transfer edge produces lcl_wr_valid_o high for exactly the next cycle. In that cycle, lcl_wr_data_o holds the AD word and lcl_wr_be_o holds the bitwise inverse of C/BE#. lcl_wr_valid_o is low in every other cycle.
- R8: On a write with lcl_wr_acc_i high in the address phase, TRDY# is low in the same cycle that DEVSEL# first goes low. There is no turnaround.
- R9: Each cycle that lcl_rd_rdy_i (read) or lcl_wr_acc_i (write) is held low before the first word delays the first TRDY# low by one cycle.
- R10: FRAME# that stays low from one edge to the next never starts a claim, even if AD and C/BE# then carry a matching address and command.
- R11: During and after reset, DEVSEL# and TRDY# are high, and ad_oe_o, lcl_rd_req_o and lcl_wr_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | FRAME# sampled from the bus |
| irdy_n_i | input | 1 | IRDY# sampled from the bus |
| ad_i | input | 32 | AD lines as seen on the bus |
| cbe_n_i | input | 4 | C/BE# lines: command in the address phase, active-low byte enables in data phases |
| devsel_n_o | output | 1 | DEVSEL# driven by the target |
| trdy_n_o | output | 1 | TRDY# driven by the target |
| ad_o | output | 32 | Read data toward the AD pads |
| ad_oe_o | output | 1 | Output enable for the AD pads |
| lcl_addr_o | output | 32 | Address latched at claim |
| lcl_cmd_o | output | 4 | Command latched at claim |
| lcl_rd_req_o | output | 1 | The controller wants the next read word this cycle |
| lcl_rd_data_i | input | 32 | Read word from the local side |
| lcl_rd_rdy_i | input | 1 | The read word is valid |
| lcl_wr_data_o | output | 32 | Captured write word |
| lcl_wr_be_o | output | 4 | Captured byte enables, active high |
| lcl_wr_valid_o | output | 1 | One-cycle strobe for a captured write word |
| lcl_wr_acc_i | input | 1 | The local side can take the next write word |

## Verification
The hardest situation to reach is the master inserting a wait state (IRDY# high) in the middle of a read burst while TRDY# is already low. In that case the presented word must be held, and the prefetch for the following word must not fire. The bench's read task takes a beat index at which it raises IRDY# for one cycle exactly when it sees TRDY# low. It then checks that AD holds and that the local fetch count still ends at the burst length. Local-side stalls before the first word are reached the same way: a task argument withholds ready for a chosen number of cycles, and the bench checks the cycle in which TRDY# first falls.

// File: rtl/pcit_pkg.sv
`timescale 1ns/1ps
package pcit_pkg;

    localparam int CMD_W = 4;
    localparam int N_CMD = 5;

    // command codes as seen on C/BE# during the address phase
    localparam logic [CMD_W-1:0] CMD_MEM_RD      = 4'b0110;
    localparam logic [CMD_W-1:0] CMD_MEM_WR      = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_MEM_RD_MULT = 4'b1100;
    localparam logic [CMD_W-1:0] CMD_MEM_RD_LINE = 4'b1110;
    localparam logic [CMD_W-1:0] CMD_MEM_WR_INV  = 4'b1111;

    localparam logic [CMD_W-1:0] CMD_TABLE [N_CMD] = '{
        CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RD_MULT, CMD_MEM_RD_LINE, CMD_MEM_WR_INV
    };

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_TURN    = 2'd1,
        PH_DATA    = 2'd2,
        PH_RELEASE = 2'd3
    } pcit_phase_e;

endpackage

// File: rtl/pcit_decode.sv
`timescale 1ns/1ps
module pcit_decode
    import pcit_pkg::*;
#(
    parameter int          DW       = 32,
    parameter int          BW       = DW / 8,
    parameter logic [DW-1:0] BAR_BASE = 32'h4000_0000,
    parameter logic [DW-1:0] BAR_MASK = 32'hFFFF_F000
) (
    input  logic [DW-1:0] ad_i,
    input  logic [BW-1:0] cbe_n_i,
    output logic          hit_o,
    output logic          is_wr_o
);

    logic [N_CMD-1:0] cmd_match;
    logic [CMD_W-1:0] cmd;

    assign cmd = cbe_n_i[CMD_W-1:0];

    for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
        assign cmd_match[g] = (cmd == CMD_TABLE[g]);
    end

    // bit 0 of the command separates writes from reads among supported codes
    assign is_wr_o = cmd[0];
    assign hit_o   = (|cmd_match) && ((ad_i & BAR_MASK) == BAR_BASE);

endmodule

// File: rtl/pcit_phase_fsm.sv
`timescale 1ns/1ps
module pcit_phase_fsm
    import pcit_pkg::*;
#(
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic [DW-1:0]    ad_i,
    input  logic [BW-1:0]    cbe_n_i,
    input  logic             hit_i,
    input  logic             is_wr_i,
    input  logic [DW-1:0]    rd_data_i,
    input  logic             rd_rdy_i,
    input  logic             wr_acc_i,
    output logic             devsel_n_o,
    output logic             trdy_n_o,
    output logic             ad_oe_o,
    output logic [DW-1:0]    ad_o,
    output logic             rd_req_o,
    output logic             wr_xfer_o,
    output logic [DW-1:0]    addr_o,
    output logic [CMD_W-1:0] cmd_o
);

    typedef struct packed {
        pcit_phase_e      ph;
        logic             frame_prev;
        logic             wr;
        logic             devsel_n;
        logic             trdy_n;
        logic             oe;
        logic [DW-1:0]    dout;
        logic [DW-1:0]    addr;
        logic [CMD_W-1:0] cmd;
    } fsm_st_t;

    fsm_st_t st_q, st_d;
    logic    xfer, last, rd_req, start;

    always_comb begin
        st_d            = st_q;
        st_d.frame_prev = frame_n_i;

        xfer   = (st_q.ph == PH_DATA) && !st_q.trdy_n && !irdy_n_i;
        last   = xfer && frame_n_i;
        start  = st_q.frame_prev && !frame_n_i && hit_i;
        rd_req = !st_q.wr &&
                 ((st_q.ph == PH_TURN) ||
                  ((st_q.ph == PH_DATA) && (st_q.trdy_n || (xfer && !frame_n_i))));

        case (st_q.ph)
            PH_IDLE: begin
                if (start) begin
                    st_d.addr     = ad_i;
                    st_d.cmd      = cbe_n_i[CMD_W-1:0];
                    st_d.wr       = is_wr_i;
                    st_d.devsel_n = 1'b0;
                    if (is_wr_i) begin
                        st_d.ph     = PH_DATA;
                        st_d.trdy_n = !wr_acc_i;
                    end else begin
                        st_d.ph     = PH_TURN;
                        st_d.trdy_n = 1'b1;
                    end
                end
            end
            PH_TURN: begin
                st_d.ph = PH_DATA;
                st_d.oe = 1'b1;
                if (rd_req && rd_rdy_i) begin
                    st_d.dout   = rd_data_i;
                    st_d.trdy_n = 1'b0;
                end
            end
            PH_DATA: begin
                if (last) begin
                    st_d.ph       = PH_RELEASE;
                    st_d.devsel_n = 1'b1;
                    st_d.trdy_n   = 1'b1;
                    st_d.oe       = 1'b0;
                end else if (st_q.wr) begin
                    if (st_q.trdy_n || xfer) begin
                        st_d.trdy_n = !wr_acc_i;
                    end
                end else if (rd_req) begin
                    if (rd_rdy_i) begin
                        st_d.dout   = rd_data_i;
                        st_d.trdy_n = 1'b0;
                    end else begin
                        st_d.trdy_n = 1'b1;
                    end
                end
            end
            PH_RELEASE: begin
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.ph         <= PH_IDLE;
            st_q.frame_prev <= 1'b1;
            st_q.devsel_n   <= 1'b1;
            st_q.trdy_n     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign devsel_n_o = st_q.devsel_n;
    assign trdy_n_o   = st_q.trdy_n;
    assign ad_oe_o    = st_q.oe;
    assign ad_o       = st_q.dout;
    assign rd_req_o   = rd_req;
    assign wr_xfer_o  = xfer && st_q.wr;
    assign addr_o     = st_q.addr;
    assign cmd_o      = st_q.cmd;

    // R2: turnaround cycle on reads
    assert_read_turnaround_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(devsel_n_o) && !st_q.wr) |-> (trdy_n_o && !ad_oe_o));

    // R3: pads driven only while the transaction is claimed
    assert_oe_needs_devsel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> !devsel_n_o);

    // R5: a master wait holds the presented read word
    assert_wait_holds_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n_o && !trdy_n_o && irdy_n_i && ad_oe_o) |=> (!trdy_n_o && $stable(ad_o)));

    // R6: last phase releases the bus for one cycle
    assert_last_phase_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!devsel_n_o && !trdy_n_o && !irdy_n_i && frame_n_i) |=>
        (devsel_n_o && trdy_n_o && !ad_oe_o));

    assert_release_lasts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n_o) |=> devsel_n_o);

    // R4: no local fetch outside a claimed transaction
    assert_req_inside_claim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !devsel_n_o);

    // R8: TRDY# is never low without DEVSEL#
    assert_trdy_needs_devsel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n_o |-> !devsel_n_o);

endmodule

// File: rtl/pcit_wr_capture.sv
`timescale 1ns/1ps
module pcit_wr_capture #(
    parameter int DW = 32,
    parameter int BW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_i,
    input  logic [DW-1:0] ad_i,
    input  logic [BW-1:0] cbe_n_i,
    output logic [DW-1:0] wr_data_o,
    output logic [BW-1:0] wr_be_o,
    output logic          wr_valid_o
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic [BW-1:0] be;
    } cap_st_t;

    cap_st_t       cap_q, cap_d;
    logic [BW-1:0] lane_en;

    for (genvar b = 0; b < BW; b++) begin : g_lane
        assign lane_en[b] = !cbe_n_i[b];
    end

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = xfer_i;
        if (xfer_i) begin
            cap_d.data = ad_i;
            cap_d.be   = lane_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_data_o  = cap_q.data;
    assign wr_be_o    = cap_q.be;
    assign wr_valid_o = cap_q.valid;

    // R7: every write transfer is handed over on the next cycle
    assert_capture_follows_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_i |=> (wr_valid_o && (wr_data_o == $past(ad_i))));

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> $past(xfer_i));

endmodule

// File: rtl/pcit_burst_target.sv
`timescale 1ns/1ps
module pcit_burst_target
    import pcit_pkg::*;
#(
    parameter int            DW       = 32,
    parameter int            BW       = DW / 8,
    parameter logic [DW-1:0] BAR_BASE = 32'h4000_0000,
    parameter logic [DW-1:0] BAR_MASK = 32'hFFFF_F000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n_i,
    input  logic             irdy_n_i,
    input  logic [DW-1:0]    ad_i,
    input  logic [BW-1:0]    cbe_n_i,
    output logic             devsel_n_o,
    output logic             trdy_n_o,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe_o,
    output logic [DW-1:0]    lcl_addr_o,
    output logic [CMD_W-1:0] lcl_cmd_o,
    output logic             lcl_rd_req_o,
    input  logic [DW-1:0]    lcl_rd_data_i,
    input  logic             lcl_rd_rdy_i,
    output logic [DW-1:0]    lcl_wr_data_o,
    output logic [BW-1:0]    lcl_wr_be_o,
    output logic             lcl_wr_valid_o,
    input  logic             lcl_wr_acc_i
);

    logic hit, is_wr, wr_xfer;

    pcit_decode #(
        .DW(DW), .BW(BW), .BAR_BASE(BAR_BASE), .BAR_MASK(BAR_MASK)
    ) u_decode (
        .ad_i    (ad_i),
        .cbe_n_i (cbe_n_i),
        .hit_o   (hit),
        .is_wr_o (is_wr)
    );

    pcit_phase_fsm #(.DW(DW), .BW(BW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n_i  (frame_n_i),
        .irdy_n_i   (irdy_n_i),
        .ad_i       (ad_i),
        .cbe_n_i    (cbe_n_i),
        .hit_i      (hit),
        .is_wr_i    (is_wr),
        .rd_data_i  (lcl_rd_data_i),
        .rd_rdy_i   (lcl_rd_rdy_i),
        .wr_acc_i   (lcl_wr_acc_i),
        .devsel_n_o (devsel_n_o),
        .trdy_n_o   (trdy_n_o),
        .ad_oe_o    (ad_oe_o),
        .ad_o       (ad_o),
        .rd_req_o   (lcl_rd_req_o),
        .wr_xfer_o  (wr_xfer),
        .addr_o     (lcl_addr_o),
        .cmd_o      (lcl_cmd_o)
    );

    pcit_wr_capture #(.DW(DW), .BW(BW)) u_wr_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_i     (wr_xfer),
        .ad_i       (ad_i),
        .cbe_n_i    (cbe_n_i),
        .wr_data_o  (lcl_wr_data_o),
        .wr_be_o    (lcl_wr_be_o),
        .wr_valid_o (lcl_wr_valid_o)
    );

    // R3: write transactions never drive the pads
    assert_write_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lcl_wr_valid_o |-> !ad_oe_o);

endmodule

// File: tb/pcit_burst_target_bench.sv
`timescale 1ns/1ps
module pcit_burst_target_bench;

    localparam logic [31:0] RD_PAT = 32'hA500_0000;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [3:0]  beats;
        logic        claim;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h4000_0010, 4'b0110, 4'd1, 1'b1},
        '{1'b0, 32'h4000_0100, 4'b1100, 4'd4, 1'b1},
        '{1'b0, 32'h4000_0FF0, 4'b1110, 4'd3, 1'b1},
        '{1'b1, 32'h4000_0020, 4'b0111, 4'd1, 1'b1},
        '{1'b1, 32'h4000_0200, 4'b1111, 4'd5, 1'b1},
        '{1'b0, 32'h5000_0000, 4'b0110, 4'd2, 1'b0},
        '{1'b1, 32'h4000_0040, 4'b0011, 4'd1, 1'b0},
        '{1'b0, 32'h4000_0000, 4'b0010, 4'd1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        rd_rdy = 1'b1;
    logic        wr_acc = 1'b1;
    logic [31:0] rd_cnt = '0;

    logic        devsel_n_o, trdy_n_o, ad_oe_o, lcl_rd_req_o, lcl_wr_valid_o;
    logic [31:0] ad_o, lcl_addr_o, lcl_wr_data_o, rd_data;
    logic [3:0]  lcl_cmd_o, lcl_wr_be_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    assign rd_data = RD_PAT + rd_cnt;

    always @(posedge clk) begin
        if (lcl_rd_req_o && rd_rdy) rd_cnt <= rd_cnt + 32'd1;
    end

    pcit_burst_target u_pcit_burst_target (
        .clk            (clk),
        .rst_n          (rst_n),
        .frame_n_i      (frame_n),
        .irdy_n_i       (irdy_n),
        .ad_i           (ad_in),
        .cbe_n_i        (cbe_n),
        .devsel_n_o     (devsel_n_o),
        .trdy_n_o       (trdy_n_o),
        .ad_o           (ad_o),
        .ad_oe_o        (ad_oe_o),
        .lcl_addr_o     (lcl_addr_o),
        .lcl_cmd_o      (lcl_cmd_o),
        .lcl_rd_req_o   (lcl_rd_req_o),
        .lcl_rd_data_i  (rd_data),
        .lcl_rd_rdy_i   (rd_rdy),
        .lcl_wr_data_o  (lcl_wr_data_o),
        .lcl_wr_be_o    (lcl_wr_be_o),
        .lcl_wr_valid_o (lcl_wr_valid_o),
        .lcl_wr_acc_i   (wr_acc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wword(input logic [31:0] a, input int k);
        return {a[15:0], 16'(k)} ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [3:0] wbe(input int k);
        case (k % 4)
            0: return 4'hF;
            1: return 4'h6;
            2: return 4'h8;
            default: return 4'h1;
        endcase
    endfunction

    task automatic run_read(input logic [31:0] a, input logic [3:0] c, input int beats,
                            input int stall, input int gap_at);
        logic [31:0] c0;
        logic [31:0] held;
        int done, iter, left, first_t;
        bit gap_pend, gap_used;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = c;
        left = stall; rd_rdy = (left == 0); c0 = rd_cnt;
        @(negedge clk);
        chk(devsel_n_o == 1'b0, "R1", "read claim devsel", devsel_n_o, 0);
        chk(lcl_addr_o == a && lcl_cmd_o == c, "R1", "latched addr/cmd",
            {lcl_addr_o, 28'h0, lcl_cmd_o}, {a, 28'h0, c});
        chk(trdy_n_o == 1'b1 && ad_oe_o == 1'b0, "R2", "turnaround trdy/oe",
            {trdy_n_o, ad_oe_o}, 2'b10);
        cbe_n = 4'h0; irdy_n = 1'b0; frame_n = (beats == 1); ad_in = 32'hDEAD_0000;
        done = 0; iter = 0; first_t = -1; gap_pend = 0; gap_used = 0; held = '0;
        while (done < beats && iter < 64) begin
            @(negedge clk);
            if (left > 0) left--;
            rd_rdy = (left == 0);
            chk(!devsel_n_o && ad_oe_o, "R3", "read data phase drives AD",
                {devsel_n_o, ad_oe_o}, 2'b01);
            if (first_t < 0 && !trdy_n_o) begin
                first_t = iter;
                chk(iter == stall, "R4", "first TRDY# cycle after turnaround", iter, stall);
            end else if (first_t < 0) begin
                chk(iter < stall, "R9", "TRDY# held while local side not ready", iter, stall);
            end
            if (gap_pend) begin
                chk(!trdy_n_o && ad_o == held, "R5", "wait cycle holds word",
                    {trdy_n_o, ad_o}, {1'b0, held});
                gap_pend = 0;
                irdy_n = 1'b0;
            end else if (!trdy_n_o && done == gap_at && !gap_used) begin
                irdy_n = 1'b1; held = ad_o; gap_pend = 1; gap_used = 1;
            end
            frame_n = (done == beats - 1);
            if (!trdy_n_o && !irdy_n) begin
                chk(ad_o == RD_PAT + c0 + 32'(done), "R5", "read word order",
                    ad_o, RD_PAT + c0 + 32'(done));
                done++;
            end
            iter++;
        end
        @(negedge clk);
        chk(devsel_n_o && trdy_n_o && !ad_oe_o, "R6", "release after last read",
            {devsel_n_o, trdy_n_o, ad_oe_o}, 3'b110);
        chk(rd_cnt == c0 + 32'(beats), "R5", "words fetched per burst",
            rd_cnt - c0, beats);
        irdy_n = 1'b1; frame_n = 1'b1; cbe_n = 4'hF; rd_rdy = 1'b1;
        @(negedge clk);
        chk(devsel_n_o == 1'b1, "R6", "released for one more cycle", devsel_n_o, 1);
    endtask

    task automatic run_write(input logic [31:0] a, input logic [3:0] c, input int beats,
                             input int stall);
        logic [31:0] exp_d;
        logic [3:0]  exp_be;
        int done, iter, left;
        bit pend;
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = c;
        left = stall; wr_acc = (left == 0);
        @(negedge clk);
        chk(devsel_n_o == 1'b0, "R1", "write claim devsel", devsel_n_o, 0);
        chk(lcl_cmd_o == c, "R1", "latched write cmd", lcl_cmd_o, c);
        if (stall == 0)
            chk(trdy_n_o == 1'b0, "R8", "write ready in first data phase", trdy_n_o, 0);
        done = 0; iter = 0; pend = 0; exp_d = '0; exp_be = '0;
        while (done < beats && iter < 64) begin
            if (iter > 0) @(negedge clk);
            if (left > 0) left--;
            wr_acc = (left == 0);
            if (pend)
                chk(lcl_wr_valid_o && lcl_wr_data_o == exp_d && lcl_wr_be_o == exp_be,
                    "R7", "write capture", {lcl_wr_valid_o, lcl_wr_be_o, lcl_wr_data_o},
                    {1'b1, exp_be, exp_d});
            else
                chk(!lcl_wr_valid_o, "R7", "no capture without transfer", lcl_wr_valid_o, 0);
            chk(!ad_oe_o, "R3", "write never drives AD", ad_oe_o, 0);
            if (iter < stall)
                chk(trdy_n_o == 1'b1, "R9", "write stall holds TRDY#", trdy_n_o, 1);
            else if (iter == stall)
                chk(trdy_n_o == 1'b0, "R9", "TRDY# after write accept", trdy_n_o, 0);
            ad_in = wword(a, done); cbe_n = ~wbe(done);
            frame_n = (done == beats - 1); irdy_n = 1'b0;
            if (!trdy_n_o) begin
                pend = 1; exp_d = wword(a, done); exp_be = wbe(done); done++;
            end else begin
                pend = 0;
            end
            iter++;
        end
        @(negedge clk);
        chk(lcl_wr_valid_o && lcl_wr_data_o == exp_d && lcl_wr_be_o == exp_be,
            "R7", "last write capture", {lcl_wr_valid_o, lcl_wr_be_o, lcl_wr_data_o},
            {1'b1, exp_be, exp_d});
        chk(devsel_n_o && trdy_n_o && !ad_oe_o, "R6", "release after last write",
            {devsel_n_o, trdy_n_o, ad_oe_o}, 3'b110);
        irdy_n = 1'b1; frame_n = 1'b1; cbe_n = 4'hF; wr_acc = 1'b1;
        @(negedge clk);
        chk(devsel_n_o == 1'b1 && !lcl_wr_valid_o, "R7", "idle after write",
            {devsel_n_o, lcl_wr_valid_o}, 2'b10);
    endtask

    task automatic run_ignored(input logic [31:0] a, input logic [3:0] c);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = a; cbe_n = c;
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'h0;
        for (int k = 0; k < 3; k++) begin
            chk(devsel_n_o == 1'b1 && !lcl_rd_req_o, "R1", "no claim outside window/cmd",
                {devsel_n_o, lcl_rd_req_o}, 2'b10);
            @(negedge clk);
        end
        irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(devsel_n_o && trdy_n_o && !ad_oe_o && !lcl_rd_req_o && !lcl_wr_valid_o,
            "R11", "reset state",
            {devsel_n_o, trdy_n_o, ad_oe_o, lcl_rd_req_o, lcl_wr_valid_o}, 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(devsel_n_o && trdy_n_o && !ad_oe_o, "R11", "idle after reset",
            {devsel_n_o, trdy_n_o, ad_oe_o}, 3'b110);

        for (int i = 0; i < NVEC; i++) begin
            if (!VECS[i].claim)       run_ignored(VECS[i].addr, VECS[i].cmd);
            else if (VECS[i].wr)      run_write(VECS[i].addr, VECS[i].cmd, int'(VECS[i].beats), 0);
            else                      run_read(VECS[i].addr, VECS[i].cmd, int'(VECS[i].beats), 0, 15);
        end

        // R9: local read stall during turnaround delays the first word
        run_read(32'h4000_0300, 4'b0110, 2, 2, 15);
        // R5: master wait state in the middle of a read burst
        run_read(32'h4000_0400, 4'b1100, 4, 0, 1);
        // R9 / R5: write accept withheld before the first word
        run_write(32'h4000_0500, 4'b0111, 3, 2);

        // R10: FRAME# already low, then a matching address appears
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; ad_in = 32'h7000_0000; cbe_n = 4'b0110;
        @(negedge clk);
        ad_in = 32'h4000_0000; cbe_n = 4'b0110; irdy_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(devsel_n_o == 1'b1, "R10", "no claim mid-frame", devsel_n_o, 1);
        end
        frame_n = 1'b1;
        @(negedge clk);
        irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk);
        chk(devsel_n_o == 1'b1 && !ad_oe_o, "R10", "bus still released",
            {devsel_n_o, ad_oe_o}, 2'b10);

        // R11: reset asserted in the middle of a read burst
        @(negedge clk);
        frame_n = 1'b0; ad_in = 32'h4000_0800; cbe_n = 4'b1100;
        @(negedge clk);
        irdy_n = 1'b0; cbe_n = 4'h0;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(devsel_n_o && trdy_n_o && !ad_oe_o, "R11", "reset during burst",
            {devsel_n_o, trdy_n_o, ad_oe_o}, 3'b110);
        frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_read(32'h4000_0010, 4'b0110, 1, 0, 15);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog: actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule